// File: doc/BRIEF.md
# Page-mode pseudo-static RAM controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM of 16-bit words with a 22-bit word address. The host hands over one request at a time on a valid/ready port: a read/write flag, an address, write data, a two-bit lane mask and a burst length. The controller turns a write into one strobed single-word write. It turns a read into a single access or a page burst of up to four words. Every analog timing minimum is met by counting clock cycles. Each counter limit is derived at elaboration from nanosecond parameters and the clock period, rounded up.

Reads stay inside one page, which is four words sharing address bits 21..2. Only bits 1..0 advance, and they wrap modulo four. Each read opens with a full random-access interval, so short page-cycle address changes only come in bounded runs and the memory's hidden refresh is never starved. After reset the device is held deselected for the power-up interval before the host is served. A deselect gap separates every pair of accesses.

Top module: `psram_page_ctrl`

## Requirements
- R1: From reset until PWRUP_NS/CLK_NS (rounded up) cycles have passed, `mem_cs1_n` is 1, `mem_cs2` is 0 and `req_ready` is 0. The counted interval ends on exactly that clock edge.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access and its deselect gap are over. Each request produces exactly one single-cycle `done` pulse.
- R3: A write holds `mem_cs1_n` and `mem_we_n` low together for at least 70 ns. Address, data and lane enables are steady for the whole pulse. `req_be[0]` high writes bits 7..0 (drives `mem_lb_n` low). `req_be[1]` high writes bits 15..8 (drives `mem_ub_n` low).
- R4: A write with `req_be` = 00 leaves the addressed word unchanged.
- R5: The first word of a read is sampled no earlier than 70 ns after the address, chip select and output enable are applied.
- R6: A read returns `req_len`+1 words (`req_len` 0..3), each with a one-cycle `rd_valid`. Word k comes from address bits 21..2 unchanged and bits 1..0 equal to (start + k) mod 4. Each further word is sampled at least 25 ns after the address change that selected it.
- R7: In `rd_data`, a lane whose `req_be` bit is 0 reads as 0.
- R8: Between two accesses `mem_cs1_n` stays high for at least 10 ns.
- R9: `mem_oe_n` is low only during reads and `mem_we_n` only during writes, never both at once.
- R10: Every access begins with its address held for a full 70 ns read interval. At most three short page-cycle address changes follow before the next such interval, so no 4 us window lacks one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address (start word for reads) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| req_len | input | 2 | Read words minus one |
| rd_valid | output | 1 | One read word present on rd_data |
| rd_data | output | 16 | Read word, disabled lanes zero |
| done | output | 1 | One-cycle end-of-request pulse |
| mem_addr | output | 22 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_dout | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_din | input | 16 | Data from the memory |

## Verification
The hardest case to reach is a long unbroken stream: more than fifty writes back to back, then page bursts one after another. Only that stream exercises the stricter write-pulse rule and the 4 us refresh window. The stimulus issues sixty writes with no idle cycles, followed by a run of four-word bursts. Throughout, a behavioural memory measures every interval in real time. That memory returns a poison value to any read sampled too early, so a miscounted timer surfaces as wrong data. Page wrap at the top of the address space and partially masked lanes are reached through directed entries in the vector table.

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl #(
  parameter int AW        = 22,
  parameter int CLK_NS    = 4,
  parameter int ACC_NS    = 70,
  parameter int PAGE_NS   = 25,
  parameter int PACC_NS   = 20,
  parameter int WPULSE_NS = 70,
  parameter int DSETUP_NS = 30,
  parameter int GAP_NS    = 10,
  parameter int PWRUP_NS  = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  input  logic [1:0]    req_len,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dout,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_din
);

  localparam int T_AA  = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int PC_NS = (PAGE_NS > PACC_NS) ? PAGE_NS : PACC_NS;
  localparam int T_PC  = (PC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_NS = (WPULSE_NS > DSETUP_NS) ? WPULSE_NS : DSETUP_NS;
  localparam int T_WP  = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_GAP = (GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_PU  = (PWRUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW    = $clog2(T_PU + 1) + 1;

  if (CLK_NS > PACC_NS) begin : g_clk_too_slow
    $error("clock period exceeds the page access time");
  end

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_WR, S_RD, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [1:0]   left;
  logic [1:0]   be_q;

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= CW'(T_PU - 1);
      left      <= '0;
      be_q      <= '0;
      mem_addr  <= '0;
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dout  <= '0;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_PWR: begin
          if (cnt == '0) begin
            st      <= S_IDLE;
            mem_cs2 <= 1'b1;
          end else cnt <= cnt - CW'(1);
        end
        S_IDLE: begin
          if (req_valid) begin
            mem_addr  <= req_addr;
            be_q      <= req_be;
            mem_lb_n  <= ~req_be[0];
            mem_ub_n  <= ~req_be[1];
            mem_cs1_n <= 1'b0;
            if (req_write) begin
              st        <= S_WR;
              mem_we_n  <= 1'b0;
              mem_dout  <= req_wdata;
              mem_dq_oe <= 1'b1;
              cnt       <= CW'(T_WP - 1);
            end else begin
              st       <= S_RD;
              mem_oe_n <= 1'b0;
              left     <= req_len;
              cnt      <= CW'(T_AA - 1);
            end
          end
        end
        S_WR: begin
          if (cnt == '0) begin
            mem_we_n  <= 1'b1;
            mem_cs1_n <= 1'b1;
            mem_dq_oe <= 1'b0;
            done      <= 1'b1;
            st        <= S_GAP;
            cnt       <= CW'(T_GAP - 1);
          end else cnt <= cnt - CW'(1);
        end
        S_RD: begin
          if (cnt == '0) begin
            rd_valid <= 1'b1;
            rd_data  <= {be_q[1] ? mem_din[15:8] : 8'h00,
                         be_q[0] ? mem_din[7:0]  : 8'h00};
            if (left == 2'd0) begin
              mem_cs1_n <= 1'b1;
              mem_oe_n  <= 1'b1;
              done      <= 1'b1;
              st        <= S_GAP;
              cnt       <= CW'(T_GAP - 1);
            end else begin
              left          <= left - 2'd1;
              mem_addr[1:0] <= mem_addr[1:0] + 2'd1;
              cnt           <= CW'(T_PC - 1);
            end
          end else cnt <= cnt - CW'(1);
        end
        S_GAP: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pwr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs2 |-> (mem_cs1_n && !req_ready));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_dout) && $stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

  p_page_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs1_n) |=> mem_cs1_n);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

// File: tb/psram_page_ctrl_test.sv
`timescale 1ns/100ps
module psram_page_ctrl_test;

  localparam int PU_NS = 2000;
  localparam int T_PU  = PU_NS / 4;
  localparam int T_GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0, req_len = '0;
  logic        req_ready, rd_valid, done;
  logic [15:0] rd_data;
  logic [21:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = 16'hBAD0;

  psram_page_ctrl #(.PWRUP_NS(PU_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe), .mem_din(mem_din));

  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [15:0] dflt(input logic [21:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  // behavioural memory with timing checks
  logic [15:0] mm [int unsigned];
  logic [15:0] refm [int unsigned];
  bit live = 0, page_ok = 0, wr_act = 0;
  int viol = 0, streak = 0;
  realtime t_rel = 0, t_addr = 0, t_cs_fall = 0, t_cs_rise = 0, t_oe = 0;
  realtime t_wstart = 0, t_we_rise = -100, t_data = 0, t_long = 0, need = 70;
  logic [21:0] prev_addr = '0;

  function automatic logic [15:0] mword(input logic [21:0] a);
    return mm.exists(a) ? mm[a] : dflt(a);
  endfunction

  always @(mem_addr) if (live) begin
    if (wr_act) viol++;
    if (!mem_cs1_n) begin
      if ($realtime - t_addr < 70.0 && $realtime - t_long > 4000.0) viol++;
      if ($realtime - t_addr >= 70.0) t_long = $realtime;
    end
    need = (page_ok && mem_addr[21:2] == prev_addr[21:2]) ? 20.0 : 70.0;
    page_ok = 0;
    prev_addr = mem_addr;
    t_addr = $realtime;
  end

  always @(mem_cs1_n) if (live) begin
    if (mem_cs1_n === 1'b0) begin
      if ($realtime - t_cs_rise < 10.0) viol++;
      if ($realtime - t_rel < PU_NS) viol++;
      if ($realtime - t_cs_rise >= 70.0) t_long = $realtime;
      t_cs_fall = $realtime;
    end else begin
      t_cs_rise = $realtime;
      page_ok = 0;
    end
  end

  always @(negedge mem_oe_n) if (live) begin
    t_oe = $realtime;
    streak = 0;
  end

  always @(mem_dout or mem_lb_n or mem_ub_n) if (live) begin
    if (wr_act) viol++;
    t_data = $realtime;
  end

  always @(mem_we_n or mem_cs1_n or mem_cs2) if (live) begin
    logic act;
    logic [15:0] w;
    act = !mem_cs1_n && mem_cs2 && !mem_we_n;
    if (act && !wr_act) begin
      wr_act = 1;
      t_wstart = $realtime;
      if ($realtime - t_we_rise < 5.0) viol++;
    end else if (!act && wr_act) begin
      wr_act = 0;
      t_we_rise = $realtime;
      streak++;
      if ($realtime - t_wstart < ((streak > 50) ? 70.0 : 55.0)) viol++;
      if ($realtime - t_data < 30.0) viol++;
      if (!(mem_lb_n && mem_ub_n)) begin
        w = mword(mem_addr);
        if (!mem_lb_n) w[7:0] = mem_dout[7:0];
        if (!mem_ub_n) w[15:8] = mem_dout[15:8];
        mm[mem_addr] = w;
      end
    end
  end

  initial begin
    #0.5;
    forever begin
      logic ok;
      logic [15:0] w;
      #1;
      if (live) begin
        if (!mem_oe_n && !mem_we_n) viol++;
        ok = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n && !(mem_lb_n && mem_ub_n)
             && ($realtime - t_addr >= need) && ($realtime - t_oe >= 35.0)
             && ($realtime - t_cs_fall >= 70.0);
        if (ok) page_ok = 1;
        w = mword(mem_addr);
        mem_din = ok ? {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]} : 16'hBAD0;
      end
    end
  end

  // checking
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] rword(input logic [21:0] a);
    return refm.exists(a) ? refm[a] : dflt(a);
  endfunction

  task automatic run_req(input logic wr, input logic [21:0] ad, input logic [15:0] dt,
                         input logic [1:0] be, input logic [1:0] ln, input string tag);
    int k, g;
    logic got;
    logic [1:0] lo;
    logic [21:0] ea;
    logic [15:0] ew, w;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = dt; req_be = be; req_len = ln;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; g = 0; got = 0;
    while (!got && g < 400) begin
      if (rd_valid) begin
        lo = ad[1:0] + 2'(k);
        ea = {ad[21:2], lo};
        w  = rword(ea);
        ew = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
        chk(tag, {16'h0, rd_data}, {16'h0, ew});
        k++;
      end
      if (done) got = 1;
      else begin
        @(negedge clk);
        g++;
      end
    end
    chk("R2 done pulse seen", {31'h0, got}, 32'd1);
    chk({tag, " word count"}, k, wr ? 0 : (ln + 1));
    if (wr) begin
      w = rword(ad);
      if (be[0]) w[7:0] = dt[7:0];
      if (be[1]) w[15:8] = dt[15:8];
      refm[ad] = w;
    end
    g = 1;
    @(negedge clk);
    chk("R2 single done pulse", {31'h0, done}, 32'd0);
    while (!req_ready && g < 50) begin
      g++;
      @(negedge clk);
    end
    chk("R8 deselect gap cycles", g, T_GAP);
  endtask

  localparam int NV = 13;
  // {write, addr, data, be, len}
  localparam logic [42:0] VEC [0:NV-1] = '{
    {1'b1, 22'h000100, 16'h1234, 2'b11, 2'd0},
    {1'b0, 22'h000100, 16'h0000, 2'b11, 2'd0},
    {1'b1, 22'h000101, 16'hABCD, 2'b01, 2'd0},
    {1'b1, 22'h000102, 16'h5678, 2'b10, 2'd0},
    {1'b1, 22'h000103, 16'h9999, 2'b00, 2'd0},
    {1'b0, 22'h000100, 16'h0000, 2'b11, 2'd3},
    {1'b0, 22'h000102, 16'h0000, 2'b11, 2'd3},
    {1'b0, 22'h3FFFFD, 16'h0000, 2'b01, 2'd1},
    {1'b1, 22'h3FFFFF, 16'hFFFF, 2'b11, 2'd0},
    {1'b0, 22'h3FFFFE, 16'h0000, 2'b11, 2'd2},
    {1'b0, 22'h000101, 16'h0000, 2'b10, 2'd0},
    {1'b1, 22'h200000, 16'h0F0F, 2'b11, 2'd0},
    {1'b0, 22'h200000, 16'h0000, 2'b11, 2'd1}
  };

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset cs1_n", {31'h0, mem_cs1_n}, 32'd1);
    chk("R1 reset cs2", {31'h0, mem_cs2}, 32'd0);
    chk("R1 reset strobes", {30'h0, mem_we_n, mem_oe_n}, 32'd3);
    chk("R1 reset ready", {31'h0, req_ready}, 32'd0);
    chk("R1 reset outputs", {30'h0, rd_valid, done}, 32'd0);
    rst_n = 1'b1;
    t_rel = $realtime;
    t_cs_rise = $realtime;
    live = 1;
    n = 0;
    while (!req_ready && n < T_PU + 100) begin
      @(negedge clk);
      n++;
      if (n == 10) chk("R1 held deselected", {30'h0, mem_cs1_n, mem_cs2}, 32'd2);
    end
    chk("R1 power-up cycles", n, T_PU);

    for (int i = 0; i < NV; i++) begin
      logic wr;
      logic [21:0] ad;
      logic [15:0] dt;
      logic [1:0] be, ln;
      string tag;
      {wr, ad, dt, be, ln} = VEC[i];
      if (wr) tag = "R3 write";
      else if (be != 2'b11) tag = "R7 lane-masked read";
      else if (ln == 2'd0) tag = "R5 single read";
      else tag = "R6 page read";
      run_req(wr, ad, dt, be, ln, tag);
    end

    run_req(1'b0, 22'h000103, 16'h0, 2'b11, 2'd0, "R4 masked-off write unchanged");
    run_req(1'b0, 22'h000101, 16'h0, 2'b11, 2'd0, "R3 lower-lane write");

    for (int i = 0; i < 60; i++)
      run_req(1'b1, 22'h001000 + 22'(i), 16'h4000 + 16'(i * 7), 2'b11, 2'd0, "R3 long write run");
    for (int i = 0; i < 20; i++)
      run_req(1'b0, 22'h001000 + 22'(i * 3), 16'h0, 2'b11, 2'd3, "R10 page burst run");

    chk("R3 R5 R8 R9 R10 memory timing violations", viol, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule